// File: doc/BRIEF.md
# Closed-Loop Frequency-Locked Voltage Index Controller

This block closes a loop around a free-running oscillator whose speed follows its supply voltage. The oscillator is outside the block. Its activity arrives as a count of oscillator edges seen in the most recent half period of the reference clock. The block runs on the reference clock.

At every sample instant it compares that count with a programmed target multiplier. It accumulates the gained error in an integrator and turns the result into a voltage-table index. That index is clamped between programmable limits and handed, with an update strobe, to a downstream voltage-command interface.

A small register file written over a plain write port sets the following:
- the operating mode and the output enable;
- the index limits and the baseline index;
- the sample divider and the loop gains;
- the frequency request, which can also force-load the integrator;
- the interrupt enables and the write-one-to-clear limit status.

Top module: `fll_volt_ctrl`

## Requirements
- R1: The mode field (address 0, bits 1:0) encodes disabled as 0, open loop as 1 and closed loop as 2. Only closed loop with a valid request lets the integrator move the index. In any other mode the target index is the baseline (safe) index, clamped.
- R2: At each sample instant in closed loop, err = multiplier − oscillator half-period count. The integrator adds err·ci and the proportional term becomes err·cf. The target index is safe + ((integrator + proportional) >>> shift), so the index rises while the count is below the multiplier and falls while it is above.
- R3: Sample instants occur once every `div` reference cycles. `div` is address 3, bits 7:0, and a value of 0 behaves as 1.
- R4: The index is always clamped to [min, max]. Address 2 holds min in bits 5:0, max in bits 13:8 and safe in bits 21:16. Reset values are 0, 63 and 1.
- R5: A request write (address 1) carries the following fields:
  - multiplier in bits 7:0;
  - scale in bits 15:8;
  - signed force value in bits 23:16;
  - valid in bit 24;
  - force-enable in bit 25.

  With valid and force-enable both set, the integrator is loaded so that the index becomes safe + force, and the proportional term is cleared.
- R6: The force value is clamped to the range −24…+24 before it is loaded.
- R7: Address 3 holds the gains: cf in bits 11:8, ci in bits 15:12, cg in bits 18:16 and a scale flag in bit 20. The shift is cg, plus 3 when the scale flag is set.
- R8: While the output enable (address 0, bit 4) is clear, the index holds its value and the integrator does not advance, in every mode. The index resets to 1.
- R9: Status bit 0 is set when the target exceeds max. Status bit 1 is set when the target is below min. Both are set only while the output is enabled. The status is cleared by writing ones to address 5, and a set in the same cycle wins over the clear.
- R10: The interrupt output is high when any status bit is set whose enable bit (address 4, bits 1:0) is also set.
- R11: A request write with valid clear zeroes the integrator and the proportional term, and returns the index to the safe value.
- R12: The update strobe is high for exactly the cycles in which the index register has just taken a new value.
- R13: The scale field of the last request is presented unchanged on the scale output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| osc_half | input | 8 | Oscillator edges counted in the last reference half period |
| vidx | output | 6 | Clamped voltage-table index |
| vidx_upd | output | 1 | Pulses when vidx changes |
| scale | output | 8 | Stored scale field |
| lim_sts | output | 2 | Limit status (bit 0 max, bit 1 min) |
| irq | output | 1 | Limit interrupt |

## Verification
The in-line properties check the following on every cycle:
- the index stays inside the limits of the previous cycle;
- the index is frozen while the output is disabled;
- the strobe never fires without an index change;
- a limit status bit only rises while the output is enabled.

The arithmetic itself can only be shown by the directed scenarios: gain and shift scaling, force clamping, integrator direction, sample spacing and the mode and valid gating. Those scenarios compare the index against values worked out from the register settings.

// File: rtl/fll_volt_ctrl.sv
module fll_volt_ctrl #(
  parameter int IDX_W     = 6,
  parameter int CNT_W     = 8,
  parameter int DIV_W     = 8,
  parameter int ACC_W     = 24,
  parameter int FORCE_LIM = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [CNT_W-1:0] osc_half,
  output logic [IDX_W-1:0] vidx,
  output logic             vidx_upd,
  output logic [7:0]       scale,
  output logic [1:0]       lim_sts,
  output logic             irq
);
  localparam logic [1:0] M_CLOSED = 2'd2;
  localparam logic signed [ACC_W-1:0] F_HI = ACC_W'(FORCE_LIM);
  localparam logic signed [ACC_W-1:0] F_LO = -ACC_W'(FORCE_LIM);
  localparam int PAD = ACC_W + 1 - IDX_W;

  logic [1:0] mode_q;
  logic oen_q, valid_q, cgs_q;
  logic [IDX_W-1:0] lo_q, hi_q, safe_q, idx_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [3:0] cf_q, ci_q;
  logic [2:0] cg_q;
  logic [CNT_W-1:0] mult_q;
  logic [7:0] scale_q;
  logic [1:0] ien_q, sts_q;
  logic upd_q;
  logic signed [ACC_W-1:0] acc_q, prop_q;

  wire wr_mode = wr_en && wr_addr == 3'd0;
  wire wr_req  = wr_en && wr_addr == 3'd1;
  wire wr_lim  = wr_en && wr_addr == 3'd2;
  wire wr_par  = wr_en && wr_addr == 3'd3;
  wire wr_ien  = wr_en && wr_addr == 3'd4;
  wire wr_clr  = wr_en && wr_addr == 3'd5;
  logic unused_bits;
  assign unused_bits = ^wr_data;

  wire [3:0] sh   = {1'b0, cg_q} + (cgs_q ? 4'd3 : 4'd0);
  wire       tick = (div_q == '0) || (cnt_q >= div_q - 1'b1);
  wire       run  = (mode_q == M_CLOSED) && valid_q;

  logic signed [CNT_W+1:0] err;
  assign err = $signed({2'b00, mult_q}) - $signed({2'b00, osc_half});
  logic signed [ACC_W-1:0] err_x;
  assign err_x = ACC_W'(err);

  logic signed [7:0] f_raw;
  logic signed [ACC_W-1:0] f_cl;
  assign f_raw = $signed(wr_data[23:16]);
  always_comb begin
    f_cl = ACC_W'(f_raw);
    if (f_cl > F_HI) f_cl = F_HI;
    else if (f_cl < F_LO) f_cl = F_LO;
  end

  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W:0] raw, lo_x, hi_x;
  logic over, under;
  logic [IDX_W-1:0] nxt;
  assign sum  = acc_q + prop_q;
  assign lo_x = $signed({{PAD{1'b0}}, lo_q});
  assign hi_x = $signed({{PAD{1'b0}}, hi_q});
  always_comb begin
    raw = $signed({{PAD{1'b0}}, safe_q});
    if (run) raw = raw + (ACC_W+1)'(sum >>> sh);
    over  = raw > hi_x;
    under = raw < lo_x;
    nxt   = over ? hi_q : under ? lo_q : raw[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; oen_q <= 1'b0;
      lo_q <= '0; hi_q <= '1; safe_q <= IDX_W'(1);
      div_q <= DIV_W'(4); cf_q <= '0; ci_q <= 4'd1; cg_q <= '0; cgs_q <= 1'b0;
      mult_q <= '0; scale_q <= '0; valid_q <= 1'b0; ien_q <= '0;
    end else begin
      if (wr_mode) begin mode_q <= wr_data[1:0]; oen_q <= wr_data[4]; end
      if (wr_lim) begin
        lo_q <= wr_data[IDX_W-1:0]; hi_q <= wr_data[IDX_W+7:8]; safe_q <= wr_data[IDX_W+15:16];
      end
      if (wr_par) begin
        div_q <= wr_data[DIV_W-1:0]; cf_q <= wr_data[11:8]; ci_q <= wr_data[15:12];
        cg_q <= wr_data[18:16]; cgs_q <= wr_data[20];
      end
      if (wr_req) begin
        mult_q <= wr_data[CNT_W-1:0]; scale_q <= wr_data[15:8]; valid_q <= wr_data[24];
      end
      if (wr_ien) ien_q <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; acc_q <= '0; prop_q <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (wr_req && !wr_data[24]) begin
        acc_q <= '0; prop_q <= '0;
      end else if (wr_req && wr_data[25]) begin
        acc_q <= f_cl <<< sh; prop_q <= '0;
      end else if (tick && run && oen_q) begin
        acc_q  <= acc_q + err_x * $signed({{(ACC_W-4){1'b0}}, ci_q});
        prop_q <= err_x * $signed({{(ACC_W-4){1'b0}}, cf_q});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_W'(1); upd_q <= 1'b0; sts_q <= '0;
    end else begin
      upd_q <= oen_q && (nxt != idx_q);
      if (oen_q) idx_q <= nxt;
      sts_q <= (sts_q & ~(wr_clr ? wr_data[1:0] : 2'b00)) | (oen_q ? {under, over} : 2'b00);
    end
  end

  assign vidx     = idx_q;
  assign vidx_upd = upd_q;
  assign scale    = scale_q;
  assign lim_sts  = sts_q;
  assign irq      = |(sts_q & ien_q);

  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (oen_q && lo_q <= hi_q) |=> (idx_q >= $past(lo_q) && idx_q <= $past(hi_q)));
  assert_idx_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oen_q |=> $stable(idx_q));
  assert_upd_on_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (idx_q != $past(idx_q)));
  assert_max_set_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[0]) |-> $past(oen_q));
  assert_min_set_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[1]) |-> $past(oen_q));
endmodule

// File: tb/sim_fll_volt_ctrl.sv
module sim_fll_volt_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] osc_half = 8'd0;
  logic [5:0] vidx;
  logic vidx_upd, irq;
  logic [7:0] scale;
  logic [1:0] lim_sts;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [5:0] prev_idx = 6'd1;

  always #10 clk = ~clk;

  fll_volt_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .osc_half(osc_half), .vidx(vidx), .vidx_upd(vidx_upd), .scale(scale), .lim_sts(lim_sts), .irq(irq));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R12: strobe agrees with index changes
  always @(negedge clk) if (rst_n && !done) begin
    if (vidx_upd != (vidx != prev_idx)) chk("R12", int'(vidx_upd), int'(vidx != prev_idx));
    prev_idx = vidx;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [31:0] rq(int mult, int sc, int f, bit v, bit fe);
    return {6'd0, fe, v, 8'(f), 8'(sc), 8'(mult)};
  endfunction

  function automatic logic [31:0] par(int dv, int cf, int ci, int cg, bit cs);
    return {11'd0, cs, 1'b0, 3'(cg), 4'(ci), 4'(cf), 8'(dv)};
  endfunction

  task automatic settle(int n); repeat (n) @(negedge clk); endtask

  task automatic t_reset;
    chk("R8 reset idx", vidx, 1); chk("R12 reset upd", vidx_upd, 0);
    chk("R9 reset sts", lim_sts, 0); chk("R10 reset irq", irq, 0);
  endtask

  task automatic t_gate;
    wr(3, par(4, 0, 0, 0, 0));
    wr(0, 32'h2);
    wr(1, rq(50, 0, 5, 1, 1));
    settle(6); chk("R8 disabled output holds", vidx, 1);
  endtask

  task automatic t_mode;
    wr(0, 32'h11); settle(4); chk("R1 open loop keeps safe", vidx, 1);
    wr(0, 32'h12); settle(4); chk("R5 force in closed loop", vidx, 6);
  endtask

  task automatic t_force_clamp;
    wr(1, rq(50, 0, 100, 1, 1)); settle(4); chk("R6 force clamp high", vidx, 25);
    wr(1, rq(50, 0, -100, 1, 1)); settle(4); chk("R4 clamp to min", vidx, 0);
    chk("R9 min status", lim_sts, 2); chk("R10 irq masked", irq, 0);
    wr(4, 32'h2); settle(1); chk("R10 irq enabled", irq, 1);
    wr(1, rq(50, 0, 0, 1, 1)); settle(4); chk("R4 back in range", vidx, 1);
    chk("R9 status sticky", lim_sts, 2);
    wr(5, 32'h2); settle(1); chk("R9 w1c clears", lim_sts, 0); chk("R10 irq drops", irq, 0);
  endtask

  task automatic t_max;
    wr(2, 32'h0001_1400); wr(1, rq(50, 0, 24, 1, 1)); settle(4);
    chk("R4 clamp to max", vidx, 20); chk("R9 max status", lim_sts, 1);
    wr(5, 32'h1); settle(1); chk("R9 set wins over clear", lim_sts, 1);
    wr(2, 32'h0001_3F00); wr(1, rq(50, 0, 0, 1, 1)); settle(3); wr(5, 32'h3); settle(1);
    chk("R9 cleared after recovery", lim_sts, 0);
  endtask

  task automatic t_gain;
    osc_half = 8'd48;
    wr(3, par(4, 4, 0, 2, 0)); wr(1, rq(56, 0, 0, 1, 1)); settle(10);
    chk("R7 proportional with cg shift", vidx, 9);
    wr(3, par(4, 4, 0, 2, 1)); settle(10);
    chk("R7 cg scale adds shift", vidx, 2);
  endtask

  task automatic t_loop;
    int v1;
    osc_half = 8'd48;
    wr(3, par(4, 0, 1, 0, 0)); wr(1, rq(50, 0, 0, 1, 1)); settle(40);
    v1 = vidx; chk("R2 index rises when slow", int'(v1 > 10), 1);
    osc_half = 8'd52; settle(20);
    chk("R2 index falls when fast", int'(vidx < v1), 1);
  endtask

  task automatic t_valid;
    wr(1, rq(50, 0, 7, 0, 1)); settle(20);
    chk("R11 invalid request returns to safe", vidx, 1);
  endtask

  task automatic t_div(int dv, int exp);
    int t0, t1, k;
    osc_half = 8'd49;
    wr(3, par(dv, 0, 1, 0, 0)); wr(1, rq(50, 0, 0, 1, 1));
    k = 0; while (!vidx_upd && k < 100) begin @(negedge clk); k++; end
    t0 = k; @(negedge clk); k++;
    while (!vidx_upd && k < 100) begin @(negedge clk); k++; end
    t1 = k;
    chk("R3 sample spacing", t1 - t0, exp);
  endtask

  task automatic t_scale;
    wr(1, rq(50, 8'hA5, 0, 1, 1)); settle(1);
    chk("R13 scale stored", scale, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    t_reset; t_gate; t_mode; t_force_clamp; t_max; t_gain; t_loop; t_valid;
    t_div(8, 8); t_div(0, 1); t_scale;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1; n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule